// File: doc/BRIEF.md
# PHY Basic Control Register with MAC-Side Isolation

This block holds the basic control register (address 0) of an Ethernet PHY management register set and turns its power and isolation bits into the state of the MAC-side data path. A management agent writes the register through a simple strobe/address/data port and reads it back on `ctrl_rdata`. Two stored bits select the power mode: `lowpwr` forces every MAC-side output low and floats the twisted-pair transmitter, and `isolate` puts every MAC-side output into high impedance and blocks the MAC-side inputs. The management port keeps working in every mode.

The isolate bit takes its reset value from the strapped PHY address. A restart-negotiation request is a self-clearing bit. It is honoured only when the same write also enables negotiation, and it is held until the negotiation engine acknowledges it. Two latching status bits, a latching-high fault flag and a latching-low link flag, are reloaded by a status read. Entering low power returns them to their defaults.

Two small state machines do the sequencing. The power FSM has the states PWR_NORMAL, PWR_ISOLATED, PWR_LOW and PWR_LOW_ISO. It moves on every clock to the state that matches the stored {lowpwr, isolate} bits, so any state can move to any other. The restart FSM has the states AN_IDLE and AN_REQ. A qualified write moves it from AN_IDLE to AN_REQ. It returns from AN_REQ to AN_IDLE on `an_ack`, or when negotiation is disabled.

Top module: `phy_ctrl_reg`

## Requirements
- R1: While reset is asserted and after it is released, `ctrl_rdata` reads 0x3000, with bit 10 (isolate) set exactly when `strap_addr` equals 0.
- R2: A write with `wr_addr` other than 0 changes no bit of `ctrl_rdata` and starts no restart. A write to address 0 stores bits 14, 13, 12, 11, 10 and 8 of `wr_data`. All other bits read 0, except bit 9, which shows the restart state.
- R3: One clock after the isolate bit (10) is stored as 1, all ten bits of `mac_oe` are 0, and `core_txd`, `core_txen` and `core_txer` are 0.
- R4: One clock after low power (bit 11) is stored as 1 with isolate 0, `mac_oe` is all ones, every MAC-side output is 0, `tp_tri` is 1 and the core transmit inputs are 0.
- R5: With low power and isolate both set, isolation wins: `mac_oe` is 0 and `tp_tri` is 1.
- R6: With low power and isolate both 0, the MAC-side outputs follow the core signals, the core transmit inputs follow the MAC transmit inputs, `mac_oe` is all ones and `tp_tri` is 0.
- R7: A write to address 0 with bits 9 and 12 both 1 makes `an_start` and read bit 9 equal 1 from the next cycle. Both stay 1 until the clock edge at which `an_ack` is sampled high, and are 0 after that edge.
- R8: A write to address 0 with bit 9 set and bit 12 clear leaves `an_start` and read bit 9 at 0.
- R9: `lh_fault` (default 0) sets when `fault_evt` is high and holds. `ll_link` (default 0) clears when `link_up` is low and holds. A `stat_rd` pulse reloads `lh_fault` from `fault_evt` and `ll_link` from `link_up`.
- R10: A write that changes bit 11 from 0 to 1 returns `lh_fault` and `ll_link` to 0, while the other control bits take the written values.
- R11: Writes and reads of the control register work normally while isolate or low power is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 5 | Strapped PHY address |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Register address of the write |
| wr_data | input | 16 | Write data |
| ctrl_rdata | output | 16 | Current value of the control register |
| an_ack | input | 1 | Negotiation engine has started |
| an_start | output | 1 | Restart request to the negotiation engine |
| link_up | input | 1 | Live link status |
| fault_evt | input | 1 | Live fault event |
| stat_rd | input | 1 | Status read pulse, reloads latches |
| lh_fault | output | 1 | Latching-high fault flag |
| ll_link | output | 1 | Latching-low link flag |
| core_txclk | input | 1 | Internal transmit clock |
| core_rxclk | input | 1 | Internal receive clock |
| core_rxdv | input | 1 | Internal receive valid |
| core_rxer | input | 1 | Internal receive error |
| core_rxd | input | 4 | Internal receive data |
| core_col | input | 1 | Internal collision |
| core_crs | input | 1 | Internal carrier sense |
| mac_txclk | output | 1 | MAC-side transmit clock |
| mac_rxclk | output | 1 | MAC-side receive clock |
| mac_rxdv | output | 1 | MAC-side receive valid |
| mac_rxer | output | 1 | MAC-side receive error |
| mac_rxd | output | 4 | MAC-side receive data |
| mac_col | output | 1 | MAC-side collision |
| mac_crs | output | 1 | MAC-side carrier sense |
| mac_oe | output | 10 | Drive enables {txclk, rxclk, rxdv, rxer, rxd[3:0], col, crs}; 1 = driven |
| mac_txd | input | 4 | MAC transmit data |
| mac_txen | input | 1 | MAC transmit enable |
| mac_txer | input | 1 | MAC transmit error |
| core_txd | output | 4 | Gated transmit data to the core |
| core_txen | output | 1 | Gated transmit enable to the core |
| core_txer | output | 1 | Gated transmit error to the core |
| tp_tri | output | 1 | Twisted-pair transmit tristate enable |

## Verification
The hardest case to reach is the one where low power is entered while both latches hold non-default values. The latching-low link bit only becomes 1 through a status read taken while the link is up. The fault bit only becomes 1 after a fault pulse. The bench therefore reads the status with the link up and pulses a fault first, and only then writes the low-power bit. It checks that both flags drop together and that the other fields keep their written values. For the isolate default, the bench sweeps all 32 strap addresses through reset.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
    localparam int REG_AW  = 5;
    localparam int REG_DW  = 16;
    localparam int MAC_OUT_W = 10;

    localparam int BIT_LOOP   = 14;
    localparam int BIT_SPEED  = 13;
    localparam int BIT_AN_EN  = 12;
    localparam int BIT_LOWPWR = 11;
    localparam int BIT_ISO    = 10;
    localparam int BIT_RESTART = 9;
    localparam int BIT_DUPLEX = 8;

    localparam logic [REG_DW-1:0] CTRL_WR_MASK = 16'h7D00;
    localparam logic [REG_DW-1:0] CTRL_RESET   = 16'h3000;

    typedef enum logic [1:0] {
        PWR_NORMAL,
        PWR_ISOLATED,
        PWR_LOW,
        PWR_LOW_ISO
    } pwr_state_t;

    typedef enum logic {
        AN_IDLE,
        AN_REQ
    } an_state_t;
endpackage

// File: rtl/phy_ctrl_regfile.sv
module phy_ctrl_regfile
    import phy_ctrl_pkg::*;
#(
    parameter logic [REG_AW-1:0] CTRL_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] strap_addr,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic              link_up,
    input  logic              fault_evt,
    input  logic              stat_rd,
    output logic [REG_DW-1:0] ctrl_q,
    output logic              ctrl_wr,
    output logic              lh_fault,
    output logic              ll_link
);
    logic lp_entry;

    assign ctrl_wr  = wr_en && (wr_addr == CTRL_ADDR);
    assign lp_entry = ctrl_wr && wr_data[BIT_LOWPWR] && !ctrl_q[BIT_LOWPWR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q          <= CTRL_RESET;
            ctrl_q[BIT_ISO] <= (strap_addr == '0);
        end else if (ctrl_wr) begin
            ctrl_q <= wr_data & CTRL_WR_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lh_fault <= 1'b0;
            ll_link  <= 1'b0;
        end else if (lp_entry) begin
            lh_fault <= 1'b0;
            ll_link  <= 1'b0;
        end else if (stat_rd) begin
            lh_fault <= fault_evt;
            ll_link  <= link_up;
        end else begin
            lh_fault <= lh_fault | fault_evt;
            ll_link  <= ll_link & link_up;
        end
    end

    assert_latch_reinit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[BIT_LOWPWR]) |-> (!lh_fault && !ll_link));

    assert_fault_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lh_fault && !stat_rd && !lp_entry) |=> lh_fault);

    assert_foreign_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != CTRL_ADDR) |=> $stable(ctrl_q));
endmodule

// File: rtl/phy_an_restart.sv
module phy_an_restart
    import phy_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic              an_en,
    input  logic              an_ack,
    output logic              an_start,
    output logic              restart_bit
);
    an_state_t state_q, state_d;
    logic      req;

    assign req = ctrl_wr && wr_data[BIT_RESTART] && wr_data[BIT_AN_EN];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AN_IDLE: if (req) state_d = AN_REQ;
            AN_REQ:  if (!an_en || an_ack) state_d = AN_IDLE;
            default: state_d = AN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= AN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        an_start    = 1'b0;
        restart_bit = 1'b0;
        unique case (state_q)
            AN_IDLE: begin
                an_start    = 1'b0;
                restart_bit = 1'b0;
            end
            AN_REQ: begin
                an_start    = 1'b1;
                restart_bit = 1'b1;
            end
            default: ;
        endcase
    end

    assert_start_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(an_start) |-> an_en);

    assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (an_start && !an_ack && an_en) |=> an_start);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (an_start && an_ack) |=> !an_start);
endmodule

// File: rtl/phy_mac_gate.sv
module phy_mac_gate
    import phy_ctrl_pkg::*;
#(
    parameter int TXD_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lowpwr,
    input  logic                 isolate,
    input  logic [MAC_OUT_W-1:0] core_out,
    output logic [MAC_OUT_W-1:0] mac_out,
    output logic [MAC_OUT_W-1:0] mac_oe,
    input  logic [TXD_W+1:0]     mac_in,
    output logic [TXD_W+1:0]     core_in,
    output logic                 tp_tri
);
    pwr_state_t state_q, state_d;
    logic       in_block;
    logic       out_zero;

    always_comb begin
        unique case ({lowpwr, isolate})
            2'b00:   state_d = PWR_NORMAL;
            2'b01:   state_d = PWR_ISOLATED;
            2'b10:   state_d = PWR_LOW;
            2'b11:   state_d = PWR_LOW_ISO;
            default: state_d = PWR_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_NORMAL;
        else        state_q <= state_d;
    end

    always_comb begin
        mac_oe   = '1;
        tp_tri   = 1'b0;
        in_block = 1'b0;
        out_zero = 1'b0;
        unique case (state_q)
            PWR_NORMAL: ;
            PWR_ISOLATED: begin
                mac_oe   = '0;
                in_block = 1'b1;
            end
            PWR_LOW: begin
                tp_tri   = 1'b1;
                in_block = 1'b1;
                out_zero = 1'b1;
            end
            PWR_LOW_ISO: begin
                mac_oe   = '0;
                tp_tri   = 1'b1;
                in_block = 1'b1;
                out_zero = 1'b1;
            end
            default: ;
        endcase
    end

    assign mac_out = out_zero ? '0 : core_out;
    assign core_in = in_block ? '0 : mac_in;

    assert_lowpwr_tri_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr |=> tp_tri);

    assert_iso_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        isolate |=> (mac_oe == '0));

    assert_lowpwr_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lowpwr && !isolate) |=> (mac_out == '0 && core_in == '0 && mac_oe == '1));
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
    import phy_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  strap_addr,
    input  logic        wr_en,
    input  logic [4:0]  wr_addr,
    input  logic [15:0] wr_data,
    output logic [15:0] ctrl_rdata,
    input  logic        an_ack,
    output logic        an_start,
    input  logic        link_up,
    input  logic        fault_evt,
    input  logic        stat_rd,
    output logic        lh_fault,
    output logic        ll_link,
    input  logic        core_txclk,
    input  logic        core_rxclk,
    input  logic        core_rxdv,
    input  logic        core_rxer,
    input  logic [3:0]  core_rxd,
    input  logic        core_col,
    input  logic        core_crs,
    output logic        mac_txclk,
    output logic        mac_rxclk,
    output logic        mac_rxdv,
    output logic        mac_rxer,
    output logic [3:0]  mac_rxd,
    output logic        mac_col,
    output logic        mac_crs,
    output logic [9:0]  mac_oe,
    input  logic [3:0]  mac_txd,
    input  logic        mac_txen,
    input  logic        mac_txer,
    output logic [3:0]  core_txd,
    output logic        core_txen,
    output logic        core_txer,
    output logic        tp_tri
);
    logic [REG_DW-1:0]    ctrl_q;
    logic                 ctrl_wr;
    logic                 restart_bit;
    logic [MAC_OUT_W-1:0] core_out, mac_out;
    logic [5:0]           mac_in, core_in;

    phy_ctrl_regfile #(.CTRL_ADDR(5'd0)) u_regs (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .link_up(link_up), .fault_evt(fault_evt), .stat_rd(stat_rd),
        .ctrl_q(ctrl_q), .ctrl_wr(ctrl_wr),
        .lh_fault(lh_fault), .ll_link(ll_link)
    );

    phy_an_restart u_an (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wr_data(wr_data),
        .an_en(ctrl_q[BIT_AN_EN]), .an_ack(an_ack),
        .an_start(an_start), .restart_bit(restart_bit)
    );

    assign core_out = {core_txclk, core_rxclk, core_rxdv, core_rxer, core_rxd, core_col, core_crs};
    assign {mac_txclk, mac_rxclk, mac_rxdv, mac_rxer, mac_rxd, mac_col, mac_crs} = mac_out;
    assign mac_in = {mac_txd, mac_txen, mac_txer};
    assign {core_txd, core_txen, core_txer} = core_in;

    phy_mac_gate #(.TXD_W(4)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .lowpwr(ctrl_q[BIT_LOWPWR]), .isolate(ctrl_q[BIT_ISO]),
        .core_out(core_out), .mac_out(mac_out), .mac_oe(mac_oe),
        .mac_in(mac_in), .core_in(core_in), .tp_tri(tp_tri)
    );

    always_comb begin
        ctrl_rdata              = ctrl_q;
        ctrl_rdata[BIT_RESTART] = restart_bit;
    end

    assert_iso_blocks_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[BIT_ISO] |=> (core_txen == 1'b0 && core_txd == 4'd0));
endmodule

// File: tb/test_phy_ctrl_reg.sv
`timescale 1ns/1ps
module test_phy_ctrl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap_addr = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] ctrl_rdata;
    logic        an_ack = 1'b0, an_start;
    logic        link_up = 1'b0, fault_evt = 1'b0, stat_rd = 1'b0;
    logic        lh_fault, ll_link;
    logic        core_txclk = 0, core_rxclk = 0, core_rxdv = 0, core_rxer = 0, core_col = 0, core_crs = 0;
    logic [3:0]  core_rxd = '0;
    logic        mac_txclk, mac_rxclk, mac_rxdv, mac_rxer, mac_col, mac_crs;
    logic [3:0]  mac_rxd;
    logic [9:0]  mac_oe;
    logic [3:0]  mac_txd = '0;
    logic        mac_txen = 0, mac_txer = 0;
    logic [3:0]  core_txd;
    logic        core_txen, core_txer, tp_tri;

    int checks = 0;
    int errors = 0;
    logic [15:0] shadow;

    always #10 clk = ~clk;

    phy_ctrl_reg i_phy_ctrl_reg (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic mode_check(input logic lp, input logic iso, input logic [9:0] pat, input logic [5:0] txp);
        logic [15:0] v;
        v = 16'h3000 | (16'(lp) << 11) | (16'(iso) << 10);
        wr(5'd0, v);
        {core_txclk, core_rxclk, core_rxdv, core_rxer, core_rxd, core_col, core_crs} = pat;
        {mac_txd, mac_txen, mac_txer} = txp;
        @(negedge clk);
        check("R11 readback", 32'(ctrl_rdata), 32'(v));
        check(iso ? (lp ? "R5 oe" : "R3 oe") : (lp ? "R4 oe" : "R6 oe"),
              32'(mac_oe), iso ? 32'h0 : 32'h3FF);
        check(lp ? "R4/R5 tp_tri" : "R6 tp_tri", 32'(tp_tri), 32'(lp));
        check((lp || iso) ? "R3/R4 tx gated" : "R6 tx pass",
              32'({core_txd, core_txen, core_txer}), (lp || iso) ? 32'h0 : 32'(txp));
        if (!iso)
            check(lp ? "R4 outputs low" : "R6 outputs pass",
                  32'({mac_txclk, mac_rxclk, mac_rxdv, mac_rxer, mac_rxd, mac_col, mac_crs}),
                  lp ? 32'h0 : 32'(pat));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        for (int a = 0; a < 32; a++) begin
            rst_n = 1'b0;
            strap_addr = 5'(a);
            @(negedge clk);
            check("R1 reset default", 32'(ctrl_rdata), (a == 0) ? 32'h3400 : 32'h3000);
            rst_n = 1'b1;
            @(negedge clk);
            @(negedge clk);
            check("R1 default after reset", 32'(ctrl_rdata), (a == 0) ? 32'h3400 : 32'h3000);
            check("R1/R3 strap isolate oe", 32'(mac_oe), (a == 0) ? 32'h0 : 32'h3FF);
        end

        for (int m = 0; m < 4; m++) begin
            mode_check(m[1], m[0], 10'h2A5, 6'h2B);
            mode_check(m[1], m[0], 10'h15A, 6'h14);
            mode_check(m[1], m[0], 10'h3FF, 6'h3F);
        end

        wr(5'd0, 16'h7D00);
        shadow = ctrl_rdata;
        for (int a = 1; a < 32; a++) begin
            wr(5'(a), 16'h0200 | 16'h1000);
            check("R2 foreign address", 32'(ctrl_rdata), 32'(shadow));
            check("R2 no restart", 32'(an_start), 32'h0);
        end
        wr(5'd0, 16'hFFFF);
        check("R2 write mask", 32'(ctrl_rdata), 32'h7F00);
        an_ack = 1'b1;
        @(negedge clk);
        an_ack = 1'b0;

        wr(5'd0, 16'h1200);
        check("R7 start raised", 32'(an_start), 32'h1);
        check("R7 bit9 reads 1", 32'(ctrl_rdata[9]), 32'h1);
        repeat (3) @(negedge clk);
        check("R7 holds without ack", 32'(an_start), 32'h1);
        an_ack = 1'b1;
        #1;
        check("R7 bit9 still 1 before ack edge", 32'(ctrl_rdata[9]), 32'h1);
        @(negedge clk);
        an_ack = 1'b0;
        check("R7 cleared after ack", 32'(an_start), 32'h0);
        check("R7 bit9 cleared", 32'(ctrl_rdata[9]), 32'h0);

        wr(5'd0, 16'h0200);
        check("R8 ignored start", 32'(an_start), 32'h0);
        check("R8 ignored bit9", 32'(ctrl_rdata), 32'h0000);
        @(negedge clk);
        check("R8 still idle", 32'(an_start), 32'h0);

        wr(5'd0, 16'h3000);
        link_up = 1'b1; stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        check("R9 link latch loaded", 32'(ll_link), 32'h1);
        check("R9 fault clear", 32'(lh_fault), 32'h0);
        fault_evt = 1'b1;
        @(negedge clk);
        fault_evt = 1'b0;
        @(negedge clk);
        check("R9 fault latched high", 32'(lh_fault), 32'h1);
        link_up = 1'b0;
        @(negedge clk);
        link_up = 1'b1;
        @(negedge clk);
        check("R9 link latched low", 32'(ll_link), 32'h0);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        check("R9 reload link", 32'(ll_link), 32'h1);
        check("R9 reload fault", 32'(lh_fault), 32'h0);
        fault_evt = 1'b1;
        @(negedge clk);
        fault_evt = 1'b0;
        wr(5'd0, 16'h7900);
        check("R10 fault reinit", 32'(lh_fault), 32'h0);
        check("R10 link reinit", 32'(ll_link), 32'h0);
        check("R10 other bits kept", 32'(ctrl_rdata), 32'h7900);
        wr(5'd0, 16'h7D00);
        check("R11 write during low power", 32'(ctrl_rdata), 32'h7D00);
        wr(5'd0, 16'h3000);
        @(negedge clk);
        check("R6 back to normal", 32'(mac_oe), 32'h3FF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule